// File: doc/BRIEF.md
# Power-Down Wake-Up Controller

This block holds the operating mode of a line-interface device and decides when a sleeping device may wake. Software selects one of four modes through a two-bit field. In the power-down mode the oscillator request is dropped. The controller then watches three kinds of wake event: an activation reported by the line receiver, a request pulled low by a slave on the attached serial bus, and clock activity started by the bus master. The line receiver's analog detection is modelled by an activity strobe followed by a verdict strobe that marks the activity as valid or as noise.

A wake event counts only when the interrupt pin is globally enabled and the enable for that kind of event is also set. An accepted wake does four things. It rewrites the mode to idle, restores the output clock selection that was programmed before sleep, pulses a restore strobe, and arms an active-low interrupt. The interrupt is asserted only after a set number of output-clock ticks has been seen. Noise on the line puts the device back to sleep without any interrupt or restore.

Top module: `pdw_ctrl`

## Requirements
- R1: After synchronous reset, mode reads 00 (idle), osc_run is 1, int_n is 1, clk_restore is 0 and clk_sel holds the default selection 0.
- R2: A mode write takes effect on the next clock edge with encoding 00 idle, 01 active voice and data, 10 active data only, 11 power-down. osc_run is 0 in power-down unless a line check is open, and 1 in every other mode.
- R3: In power-down, a line_act strobe opens a line check, and osc_run reads 1 from the next edge until a verdict arrives.
- R4: A verdict with line_valid=0 (noise) closes the check. Mode stays 11, osc_run returns to 0, and neither clk_restore nor int_n changes.
- R5: A verdict with line_valid=1 while int_dis=0 and f7_ie=1 wakes the device. On the next edge mode reads 00 and clk_restore is 1 for exactly one cycle.
- R6: With bus_master=1, a falling bus_req_n wakes the device when int_dis=0 and tmr_ie=1. Mode reads 00 on the third edge after the change.
- R7: With bus_master=0, a rising bus_clk wakes the device under the same enables, also on the third edge.
- R8: A wake event is ignored and mode stays 11 if int_dis=1, if its own enable is 0, or if it belongs to the bus role that is not selected.
- R9: After a wake, int_n stays 1 until HOLD_TICKS (2) oclk_tick cycles have been registered. It falls on the edge that registers the second tick and returns to 1 on int_ack.
- R10: In power-down clk_sel shows the stop code (all ones). A wake restores the rate last written through rate_we, including writes made during power-down. Reset restores the default 0.
- R11: While int_dis=1, int_n reads 1 on the following edge even if an interrupt is pending. Clearing int_dis brings the pending interrupt back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wd | input | 2 | Mode write data |
| int_dis | input | 1 | Global interrupt pin disable (1 = disabled) |
| f7_ie | input | 1 | Enable for line activation wake |
| tmr_ie | input | 1 | Enable for serial-bus timing request wake |
| bus_master | input | 1 | 1 = device is bus clock master, 0 = slave |
| rate_we | input | 1 | Clock rate write strobe |
| rate_wd | input | 3 | Clock rate write data |
| line_act | input | 1 | Line receiver saw activity |
| line_verdict | input | 1 | Line receiver verdict strobe |
| line_valid | input | 1 | Verdict: 1 = valid activation, 0 = noise |
| bus_req_n | input | 1 | Asynchronous serial-bus request from slave, active low |
| bus_clk | input | 1 | Asynchronous serial-bus clock from master |
| oclk_tick | input | 1 | One pulse per output-clock cycle |
| int_ack | input | 1 | Clears a pending interrupt |
| mode | output | 2 | Current mode |
| osc_run | output | 1 | Oscillator run request |
| clk_sel | output | 3 | Output clock selection |
| clk_restore | output | 1 | One-cycle strobe on accepted wake |
| int_n | output | 1 | Interrupt pin, active low |

## Verification
Mode writes and line verdicts show their result on the first rising edge. The two bus pins pass through a two-stage synchronizer and an edge register, so their wake is due on the third edge. clk_sel, osc_run and clk_restore change on the same edge as mode. int_n falls on the edge that registers the second tick after the wake and rises on the edge after int_ack or int_dis. The bench drives every input at a falling edge, waits for exactly the number of falling edges that these counts require, and samples there. For the bus paths it also checks the edge before the due one, to confirm the result does not arrive early.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE       = 2'b00,
    MODE_VOICE_DATA = 2'b01,
    MODE_DATA_ONLY  = 2'b10,
    MODE_POWER_DOWN = 2'b11
  } pdw_mode_e;

  localparam int SRC_LINE = 0;
  localparam int SRC_BUS  = 1;
  localparam int NUM_SRC  = 2;
endpackage

// File: rtl/pdw_sync_edge.sv
module pdw_sync_edge #(
  parameter int STAGES = 2,
  parameter bit RISE   = 1'b1,
  parameter bit IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sq;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq     <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sq     <= {sq[STAGES-2:0], din};
      prev_q <= sq[LAST];
    end
  end

  generate
    if (RISE) begin : g_rise
      assign edge_o = sq[LAST] & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sq[LAST] & prev_q;
    end
  endgenerate
endmodule

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual #(
  parameter int N = 2
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] ie,
  input  logic         glob_en,
  output logic         wake
);
  logic [N-1:0] hit;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      assign hit[i] = evt[i] & ie[i] & glob_en;
    end
  endgenerate

  assign wake = |hit;
endmodule

// File: rtl/pdw_int_hold.sv
module pdw_int_hold #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  input  logic tick,
  input  logic ack,
  input  logic mask,
  output logic int_n
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          int_n_q, int_n_d;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (wake) begin
      pend_d = 1'b1;
      cnt_d  = '0;
    end else begin
      if (ack) pend_d = 1'b0;
      if (pend_q && tick && (cnt_q < HOLD_C)) cnt_d = cnt_q + 1'b1;
    end
    int_n_d = !(pend_d && (cnt_d == HOLD_C) && !mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      int_n_q <= 1'b1;
    end else begin
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
      int_n_q <= int_n_d;
    end
  end

  assign int_n = int_n_q;
endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
  import pdw_pkg::*;
#(
  parameter int              RATE_W      = 3,
  parameter int              SYNC_STAGES = 2,
  parameter int              HOLD_TICKS  = 2,
  parameter logic [RATE_W-1:0] DEFAULT_SEL = '0,
  parameter logic [RATE_W-1:0] STOP_SEL    = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [1:0]        mode_wd,
  input  logic              int_dis,
  input  logic              f7_ie,
  input  logic              tmr_ie,
  input  logic              bus_master,
  input  logic              rate_we,
  input  logic [RATE_W-1:0] rate_wd,
  input  logic              line_act,
  input  logic              line_verdict,
  input  logic              line_valid,
  input  logic              bus_req_n,
  input  logic              bus_clk,
  input  logic              oclk_tick,
  input  logic              int_ack,
  output logic [1:0]        mode,
  output logic              osc_run,
  output logic [RATE_W-1:0] clk_sel,
  output logic              clk_restore,
  output logic              int_n
);
  pdw_mode_e         mode_q, mode_d;
  logic              chk_q, chk_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [RATE_W-1:0] sel_q, sel_d;
  logic              osc_q, osc_d;
  logic              restore_q;

  logic              in_pd;
  logic              req_fall, clk_rise;
  logic              bus_evt, line_evt;
  logic [NUM_SRC-1:0] src_evt, src_ie;
  logic              wake;

  assign in_pd = (mode_q == MODE_POWER_DOWN);

  pdw_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b0), .IDLE(1'b1)) u_req_sync (
    .clk(clk), .rst(rst), .din(bus_req_n), .edge_o(req_fall)
  );

  pdw_sync_edge #(.STAGES(SYNC_STAGES), .RISE(1'b1), .IDLE(1'b0)) u_clk_sync (
    .clk(clk), .rst(rst), .din(bus_clk), .edge_o(clk_rise)
  );

  assign bus_evt  = in_pd & (bus_master ? req_fall : clk_rise);
  assign line_evt = in_pd & chk_q & line_verdict & line_valid;

  always_comb begin
    src_evt           = '0;
    src_ie            = '0;
    src_evt[SRC_LINE] = line_evt;
    src_evt[SRC_BUS]  = bus_evt;
    src_ie[SRC_LINE]  = f7_ie;
    src_ie[SRC_BUS]   = tmr_ie;
  end

  pdw_wake_qual #(.N(NUM_SRC)) u_qual (
    .evt(src_evt), .ie(src_ie), .glob_en(!int_dis), .wake(wake)
  );

  always_comb begin
    if (wake)         mode_d = MODE_IDLE;
    else if (mode_we) mode_d = pdw_mode_e'(mode_wd);
    else              mode_d = mode_q;

    if (!in_pd || wake)               chk_d = 1'b0;
    else if (chk_q && line_verdict)   chk_d = 1'b0;
    else if (line_act)                chk_d = 1'b1;
    else                              chk_d = chk_q;

    rate_d = rate_we ? rate_wd : rate_q;
    sel_d  = (mode_d == MODE_POWER_DOWN) ? STOP_SEL : rate_d;
    osc_d  = (mode_d != MODE_POWER_DOWN) | chk_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_IDLE;
      chk_q     <= 1'b0;
      rate_q    <= DEFAULT_SEL;
      sel_q     <= DEFAULT_SEL;
      osc_q     <= 1'b1;
      restore_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      chk_q     <= chk_d;
      rate_q    <= rate_d;
      sel_q     <= sel_d;
      osc_q     <= osc_d;
      restore_q <= wake;
    end
  end

  pdw_int_hold #(.HOLD(HOLD_TICKS)) u_int (
    .clk(clk), .rst(rst), .wake(wake), .tick(oclk_tick),
    .ack(int_ack), .mask(int_dis), .int_n(int_n)
  );

  assign mode        = mode_q;
  assign osc_run     = osc_q;
  assign clk_sel     = sel_q;
  assign clk_restore = restore_q;
endmodule

// File: rtl/pdw_ctrl_chk.sv
module pdw_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_we,
  input logic       int_dis,
  input logic       line_verdict,
  input logic       line_valid,
  input logic       oclk_tick,
  input logic       bus_evt,
  input logic [1:0] mode,
  input logic       osc_run,
  input logic       clk_restore,
  input logic       int_n
);
  logic [1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst)                            tick_cnt <= 2'd0;
    else if (clk_restore)               tick_cnt <= {1'b0, oclk_tick};
    else if (oclk_tick && tick_cnt != 2'd3) tick_cnt <= tick_cnt + 2'd1;
  end

  // R5: restore strobe lasts a single cycle
  p_restore_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    clk_restore |=> !clk_restore);

  // R5: the restore strobe coincides with idle mode
  p_wake_idle_r5: assert property (@(posedge clk) disable iff (rst)
    clk_restore |-> (mode == 2'b00));

  // R2: every mode other than power-down runs the oscillator
  p_osc_active_r2: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b11) |-> osc_run);

  // R4: a noise verdict never leaves power-down
  p_noise_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && line_verdict && !line_valid && !mode_we && !bus_evt)
      |=> (mode == 2'b11 && !clk_restore));

  // R11: a disabled pin stays high
  p_int_mask_r11: assert property (@(posedge clk) disable iff (rst)
    $past(int_dis) |-> int_n);

  // R9: the pin falls only after two ticks since the wake
  p_int_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(int_n) |-> (tick_cnt >= 2'd2));
endmodule

bind pdw_ctrl pdw_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .mode_we(mode_we), .int_dis(int_dis),
  .line_verdict(line_verdict), .line_valid(line_valid),
  .oclk_tick(oclk_tick), .bus_evt(bus_evt), .mode(mode),
  .osc_run(osc_run), .clk_restore(clk_restore), .int_n(int_n)
);

// File: tb/tb_pdw_ctrl.sv
module tb_pdw_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_we = 0, int_dis = 0, f7_ie = 0, tmr_ie = 0, bus_master = 0;
  logic [1:0] mode_wd = 0;
  logic       rate_we = 0;
  logic [2:0] rate_wd = 0;
  logic       line_act = 0, line_verdict = 0, line_valid = 0;
  logic       bus_req_n = 1, bus_clk = 0, oclk_tick = 0, int_ack = 0;
  logic [1:0] mode;
  logic       osc_run, clk_restore, int_n;
  logic [2:0] clk_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdw_ctrl dut (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wd(mode_wd),
    .int_dis(int_dis), .f7_ie(f7_ie), .tmr_ie(tmr_ie), .bus_master(bus_master),
    .rate_we(rate_we), .rate_wd(rate_wd), .line_act(line_act),
    .line_verdict(line_verdict), .line_valid(line_valid),
    .bus_req_n(bus_req_n), .bus_clk(bus_clk), .oclk_tick(oclk_tick),
    .int_ack(int_ack), .mode(mode), .osc_run(osc_run), .clk_sel(clk_sel),
    .clk_restore(clk_restore), .int_n(int_n)
  );

  // wdata[7:6], expected mode [5:4], osc_run [3], clk_sel [2:0]
  localparam logic [7:0] VEC [5] = '{
    8'b01_01_1_101, 8'b10_10_1_101, 8'b11_11_0_111,
    8'b00_00_1_101, 8'b11_11_0_111
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] v);
    mode_we = 1; mode_wd = v; cyc(1); mode_we = 0;
  endtask

  task automatic line_seq(input logic valid);
    line_act = 1; cyc(1); line_act = 0;
    line_verdict = 1; line_valid = valid; cyc(1); line_verdict = 0; line_valid = 0;
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", n);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 mode", mode, 2'b00);
    chk("R1 osc_run", osc_run, 1);
    chk("R1 int_n", int_n, 1);
    chk("R1 clk_restore", clk_restore, 0);
    chk("R1 clk_sel", clk_sel, 0);

    rate_we = 1; rate_wd = 3'd5; cyc(1); rate_we = 0;

    for (int i = 0; i < 5; i++) begin
      wr_mode(VEC[i][7:6]);
      chk("R2 mode", mode, VEC[i][5:4]);
      chk("R2 osc_run", osc_run, VEC[i][3]);
      chk("R10 clk_sel", clk_sel, VEC[i][2:0]);
    end

    // R3 / R4: noise in power-down
    f7_ie = 1;
    line_act = 1; cyc(1); line_act = 0;
    chk("R3 osc_run on check", osc_run, 1);
    chk("R3 mode", mode, 2'b11);
    line_verdict = 1; line_valid = 0; cyc(1); line_verdict = 0;
    chk("R4 mode", mode, 2'b11);
    chk("R4 osc_run", osc_run, 0);
    chk("R4 clk_restore", clk_restore, 0);
    cyc(3);
    chk("R4 int_n", int_n, 1);

    // R8: unqualified events
    f7_ie = 0;
    line_seq(1);
    chk("R8 f7 disabled", mode, 2'b11);
    chk("R8 no restore", clk_restore, 0);
    f7_ie = 1; tmr_ie = 1; bus_master = 0;
    bus_req_n = 0; cyc(4);
    chk("R8 wrong role", mode, 2'b11);
    bus_req_n = 1; cyc(4);
    bus_master = 1; tmr_ie = 0;
    bus_req_n = 0; cyc(4);
    chk("R8 tmr disabled", mode, 2'b11);
    bus_req_n = 1; cyc(4);
    tmr_ie = 1; int_dis = 1;
    bus_req_n = 0; cyc(4);
    chk("R8 pin disabled", mode, 2'b11);
    bus_req_n = 1; cyc(4);
    int_dis = 0;

    // R5 / R9: line wake
    line_seq(1);
    chk("R5 mode idle", mode, 2'b00);
    chk("R5 restore", clk_restore, 1);
    chk("R10 sel restored", clk_sel, 3'd5);
    chk("R5 osc_run", osc_run, 1);
    chk("R9 int held", int_n, 1);
    cyc(1);
    chk("R5 restore single", clk_restore, 0);
    oclk_tick = 1; cyc(1);
    chk("R9 after one tick", int_n, 1);
    cyc(1); oclk_tick = 0;
    chk("R9 after two ticks", int_n, 0);
    int_ack = 1; cyc(1); int_ack = 0;
    chk("R9 ack", int_n, 1);

    // R6: master role wake; R10 rate written during sleep
    wr_mode(2'b11);
    rate_we = 1; rate_wd = 3'd2; cyc(1); rate_we = 0;
    chk("R10 stop code", clk_sel, 3'b111);
    bus_master = 1;
    bus_req_n = 0; cyc(2);
    chk("R6 not early", mode, 2'b11);
    cyc(1);
    chk("R6 mode idle", mode, 2'b00);
    chk("R10 sel new rate", clk_sel, 3'd2);
    bus_req_n = 1;
    int_ack = 1; cyc(1); int_ack = 0;

    // R7: slave role wake
    wr_mode(2'b11);
    bus_master = 0;
    bus_clk = 1; cyc(2);
    chk("R7 not early", mode, 2'b11);
    cyc(1);
    chk("R7 mode idle", mode, 2'b00);
    bus_clk = 0;

    // R11: masking a pending interrupt
    oclk_tick = 1; cyc(2); oclk_tick = 0;
    chk("R11 pending low", int_n, 0);
    int_dis = 1; cyc(1);
    chk("R11 masked", int_n, 1);
    int_dis = 0; cyc(1);
    chk("R11 unmasked", int_n, 0);
    int_ack = 1; cyc(1); int_ack = 0;

    // R10: reset selects default rate
    wr_mode(2'b11);
    rst = 1; cyc(1); rst = 0;
    chk("R10 reset sel", clk_sel, 3'd0);
    chk("R1 reset mode", mode, 2'b00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule